// File: doc/BRIEF.md
# Filtered Fault Trigger Detector

This block turns one of two asynchronous level inputs into a fault trigger. One input is an external interrupt pin and the other is an analog comparator output. Both inputs are always brought onto the system clock through their own two-flop synchronizers. A select input then chooses which synchronized level is used. That level can pass through an optional glitch filter, which accepts a new level only after it has been seen for four consecutive clock samples. A polarity-configurable edge detector follows. When it sees a matching edge, it raises a one-cycle trigger pulse and sets a fault flag that stays set until software clears it.

The filter and the synchronizers run on the undivided system clock. Software can force a trigger by driving the interrupt pin. The polarity is folded into the level before the edge register. Because of this, changing the source or the edge polarity while the inputs sit still can itself create a detected edge. The flag can be cleared straight after such a change.

Top module: `fault_trigger_detect`

## Requirements
- R1: `src_cmp_i`=0 selects the interrupt pin and `src_cmp_i`=1 selects the comparator input. Activity on the input that is not selected never produces a trigger.
- R2: With the filter off, a qualifying change on the selected input makes `trig_pulse_o` and `fault_flag_o` rise at the third rising clock edge after the change.
- R3: With the filter on (`filt_en_i`=1), a level held for fewer than four clock samples is rejected. A level held for four or more samples is passed.
- R4: Turning the filter on adds exactly four clock cycles, so the trigger appears at the seventh rising edge after the input change.
- R5: `fall_edge_i`=0 detects rising edges and `fall_edge_i`=1 detects falling edges of the selected, optionally filtered level.
- R6: Each detected edge gives exactly one cycle of `trig_pulse_o`.
- R7: `fault_flag_o` rises together with the trigger pulse and stays set until `flag_clr_i` is sampled high. It then reads 0 from the next cycle on.
- R8: If a detected edge and `flag_clr_i` fall in the same cycle, the flag stays set.
- R9: A change of `src_cmp_i` or `fall_edge_i` that moves the level seen by the edge detector to its active side raises a trigger and sets the flag. The flag can be cleared right afterwards.
- R10: During and after synchronous reset (`rst`=1), both outputs are 0. Releasing reset produces no trigger, whatever the input levels are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| cmp_pin_i | input | 1 | Analog comparator output (asynchronous) |
| src_cmp_i | input | 1 | Source select: 0 pin, 1 comparator |
| filt_en_i | input | 1 | Enables the four-sample glitch filter |
| fall_edge_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| flag_clr_i | input | 1 | Clears the fault flag |
| fault_flag_o | output | 1 | Sticky fault flag |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |

## Verification
The hardest case to reach is a detected edge that lands in exactly the same cycle as the clear strobe. The bench gets there by counting the three register stages from a pin change. It then raises the clear so that the clear is sampled on the very edge that registers the trigger. The filter threshold is swept exhaustively: pulse widths one through six cycles are applied for each source, each polarity and with the filter both on and off. Only widths of four or more must pass the filter.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  localparam int NUM_SRC = 2;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } src_sel_e;
endpackage

// File: rtl/ftd_sync.sv
// Plain flop chain bringing an asynchronous level onto clk.
module ftd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= din;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ftd_glitch_filter.sv
// Output follows input only after SAMPLES consecutive equal samples.
// The live sample plus SAMPLES-1 stored ones are compared, giving
// exactly SAMPLES cycles of added latency.
module ftd_glitch_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int HW = SAMPLES - 1;

  logic [HW-1:0] hist;
  logic          all_hi;
  logic          all_lo;

  assign all_hi = &{hist, din};
  assign all_lo = ~|{hist, din};

  generate
    if (HW == 1) begin : g_h1
      always_ff @(posedge clk) begin
        if (rst) hist <= din;
        else     hist <= din;
      end
    end else begin : g_hn
      always_ff @(posedge clk) begin
        if (rst) hist <= {HW{din}};
        else     hist <= {hist[HW-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         dout <= din;
    else if (all_hi) dout <= 1'b1;
    else if (all_lo) dout <= 1'b0;
  end
endmodule

// File: rtl/ftd_edge_flag.sv
// Rising-edge detector on a polarity-adjusted level, with sticky flag.
module ftd_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic flag,
  output logic trig
);
  logic prev;
  logic hit;

  assign hit = lvl & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= lvl;
      trig <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= lvl;
      trig <= hit;
      flag <= hit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/fault_trigger_detect.sv
module fault_trigger_detect #(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_pin_i,
  input  logic cmp_pin_i,
  input  logic src_cmp_i,
  input  logic filt_en_i,
  input  logic fall_edge_i,
  input  logic flag_clr_i,
  output logic fault_flag_o,
  output logic trig_pulse_o
);
  import ftd_pkg::*;

  logic [NUM_SRC-1:0] raw_lvl;
  logic [NUM_SRC-1:0] synced;
  logic               sel_lvl;
  logic               filt_lvl;
  logic               det_lvl;

  assign raw_lvl[SRC_PIN] = ext_pin_i;
  assign raw_lvl[SRC_CMP] = cmp_pin_i;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      ftd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (raw_lvl[i]),
        .dout (synced[i])
      );
    end
  endgenerate

  assign sel_lvl = synced[src_cmp_i];

  ftd_glitch_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .din  (sel_lvl),
    .dout (filt_lvl)
  );

  assign det_lvl = (filt_en_i ? filt_lvl : sel_lvl) ^ fall_edge_i;

  ftd_edge_flag u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (det_lvl),
    .clr  (flag_clr_i),
    .flag (fault_flag_o),
    .trig (trig_pulse_o)
  );
endmodule

// File: rtl/fault_trigger_detect_chk.sv
module fault_trigger_detect_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic flag,
  input logic trig,
  input logic lvl_sync,
  input logic lvl_filt
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 3'd0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_trig_single_R6: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  assert_flag_with_trig_R7: assert property (@(posedge clk) disable iff (rst)
    trig |-> flag);

  assert_flag_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> trig);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  assert_clear_vs_edge_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flag == trig));

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd0) |-> (!trig && !flag));

  assert_filter_agree_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && lvl_filt != $past(lvl_filt)) |->
      ($past(lvl_sync) == lvl_filt && $past(lvl_sync, 2) == lvl_filt &&
       $past(lvl_sync, 3) == lvl_filt && $past(lvl_sync, 4) == lvl_filt));
endmodule

bind fault_trigger_detect fault_trigger_detect_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (flag_clr_i),
  .flag     (fault_flag_o),
  .trig     (trig_pulse_o),
  .lvl_sync (sel_lvl),
  .lvl_filt (filt_lvl)
);

// File: tb/fault_trigger_detect_test.sv
module fault_trigger_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0;
  logic cmp_pin = 1'b0;
  logic src_cmp = 1'b0;
  logic filt_en = 1'b0;
  logic fall_edge = 1'b0;
  logic flag_clr = 1'b0;
  logic fault_flag;
  logic trig_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int tcnt;

  always #10 clk = ~clk;

  fault_trigger_detect uut (
    .clk          (clk),
    .rst          (rst),
    .ext_pin_i    (ext_pin),
    .cmp_pin_i    (cmp_pin),
    .src_cmp_i    (src_cmp),
    .filt_en_i    (filt_en),
    .fall_edge_i  (fall_edge),
    .flag_clr_i   (flag_clr),
    .fault_flag_o (fault_flag),
    .trig_pulse_o (trig_pulse)
  );

  task automatic check(input int act, input int exp, input string req);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig_pulse) tcnt++;
    end
  endtask

  task automatic set_pin(input logic cmp, input logic v);
    if (cmp) cmp_pin = v;
    else     ext_pin = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    tcnt = 0;
  endtask

  // R2 / R4 / R5: latency from an active-going change to the trigger
  task automatic latency(input logic cmp, input logic en, input logic fall);
    int n;
    src_cmp = cmp; filt_en = en; fall_edge = fall;
    ext_pin = fall; cmp_pin = fall;
    do_reset();
    wait_cnt(10);
    @(negedge clk);
    set_pin(cmp, ~fall);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (trig_pulse) break;
    end
    check(n, en ? 7 : 3, en ? "R4 filtered latency" : "R2 bypass latency");
    check(int'(fault_flag), 1, "R7 flag with trigger");
    @(negedge clk);
    check(int'(trig_pulse), 0, "R6 one-cycle pulse");
  endtask

  // R3 / R5 / R6: pulse width sweep
  task automatic pulse(input logic cmp, input logic en, input logic fall,
                       input int w);
    int exp;
    src_cmp = cmp; filt_en = en; fall_edge = fall;
    ext_pin = 1'b0; cmp_pin = 1'b0;
    do_reset();
    wait_cnt(8);
    tcnt = 0;
    @(negedge clk);
    set_pin(cmp, 1'b1);
    wait_cnt(w);
    set_pin(cmp, 1'b0);
    wait_cnt(14);
    exp = (en && w < 4) ? 0 : 1;
    check(tcnt, exp, "R3 R5 R6 pulse trigger count");
    check(int'(fault_flag), exp, "R3 R7 pulse flag");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state and no false edge with inputs high
    ext_pin = 1'b1; cmp_pin = 1'b1;
    repeat (4) @(negedge clk);
    check(int'(fault_flag), 0, "R10 flag in reset");
    check(int'(trig_pulse), 0, "R10 trig in reset");
    for (int e = 0; e < 2; e++) begin
      filt_en = e[0];
      do_reset();
      wait_cnt(12);
      check(tcnt, 0, "R10 no trigger after reset");
      check(int'(fault_flag), 0, "R10 no flag after reset");
    end

    // R2, R4, R5 latency for each source, filter and polarity
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++)
          latency(c[0], e[0], f[0]);

    // R3 exhaustive pulse widths
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++)
          for (int w = 1; w <= 6; w++)
            pulse(c[0], e[0], f[0], w);

    // R5: opposite edge ignored (rising-only, pin falls)
    src_cmp = 1'b0; filt_en = 1'b0; fall_edge = 1'b0;
    ext_pin = 1'b1; cmp_pin = 1'b0;
    do_reset();
    wait_cnt(6);
    tcnt = 0;
    ext_pin = 1'b0;
    wait_cnt(8);
    check(tcnt, 0, "R5 opposite edge ignored");

    // R1: unselected input ignored, both directions
    for (int c = 0; c < 2; c++) begin
      src_cmp = c[0]; filt_en = 1'b0; fall_edge = 1'b0;
      ext_pin = 1'b0; cmp_pin = 1'b0;
      do_reset();
      wait_cnt(6);
      tcnt = 0;
      set_pin(~c[0], 1'b1);
      wait_cnt(6);
      set_pin(~c[0], 1'b0);
      wait_cnt(8);
      check(tcnt, 0, "R1 unselected input ignored");
      check(int'(fault_flag), 0, "R1 unselected flag clear");
    end

    // R7 sticky flag and clear; R8 edge wins over clear
    src_cmp = 1'b0; filt_en = 1'b0; fall_edge = 1'b0;
    ext_pin = 1'b0; cmp_pin = 1'b0;
    do_reset();
    wait_cnt(6);
    @(negedge clk);
    ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    check(int'(trig_pulse), 1, "R8 trigger in clear cycle");
    check(int'(fault_flag), 1, "R8 edge beats clear");
    flag_clr = 1'b0;
    wait_cnt(10);
    check(int'(fault_flag), 1, "R7 flag sticky");
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(int'(fault_flag), 0, "R7 clear takes effect");
    wait_cnt(4);
    check(int'(fault_flag), 0, "R7 stays cleared");

    // R9: source switch raises a trigger, then clearable
    ext_pin = 1'b0; cmp_pin = 1'b1; src_cmp = 1'b0;
    do_reset();
    wait_cnt(6);
    check(int'(fault_flag), 0, "R9 quiet before switch");
    src_cmp = 1'b1;
    @(negedge clk);
    check(int'(fault_flag), 1, "R9 source switch sets flag");
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_cnt(4);
    check(int'(fault_flag), 0, "R9 flag cleared after switch");

    // R9: polarity switch raises a trigger
    ext_pin = 1'b0; cmp_pin = 1'b0; src_cmp = 1'b0; fall_edge = 1'b0;
    do_reset();
    wait_cnt(6);
    fall_edge = 1'b1;
    @(negedge clk);
    check(int'(trig_pulse), 1, "R9 polarity switch triggers");
    check(int'(fault_flag), 1, "R9 polarity switch sets flag");
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(int'(fault_flag), 0, "R9 cleared after polarity switch");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule